// File: doc/BRIEF.md
# Most-Recent-First Tag Allocator

This block keeps the pool of tags that name outstanding commands. A requester asks for a tag and receives one in the same cycle, together with a grant strobe. When a command finishes, its tag is handed back. Free tags are kept on a singly linked stack. Each tag holds a pointer to the next free tag, and a head register points at the top of the stack. A pointer value of all ones is the null sentinel, which marks the end of the list. Because the stack is last in, first out, the tag that was returned most recently is the next one handed out.

Each tag also carries an in-use bit. A release of a tag that is not currently allocated is rejected with an error strobe and changes nothing. When an allocate and a valid release arrive in the same cycle, the release is applied first, so the requester receives the tag that was just released and the list is left untouched. A free-tag count and an empty flag are provided for flow control upstream.

Top module: `tagpool_top`

## Requirements
- R1: After reset the pool holds all NUM_TAGS tags, free_cnt equals NUM_TAGS, and back-to-back allocations with no releases return tags 0, 1, 2 and so on in ascending order.
- R2: When alloc_req is high and a tag is free, alloc_grant is high in the same cycle and alloc_tag carries the tag at the head of the list. That tag is removed from the pool at the next clock edge.
- R3: When alloc_req is high and no tag is free (with no valid release in the same cycle), alloc_grant is low and alloc_tag is the null value, all ones (31 for the default width of 5 bits).
- R4: A valid release pushes the tag onto the head of the list. Later allocations return released tags in reverse order of release.
- R5: A valid release and an allocate in the same cycle grant the released tag in that cycle, and leave free_cnt and the list unchanged.
- R6: A release whose tag is not in use, or whose value is NUM_TAGS or above (including all ones), raises rel_err in the same cycle and leaves the list and free_cnt unchanged. An allocate in that same cycle is served normally from the head.
- R7: free_cnt always equals the number of free tags, and empty is high exactly when free_cnt is 0.
- R8: Releasing a tag clears its in-use mark, so a second release of the same tag without an allocation in between is rejected as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| alloc_req | input | 1 | Request one tag this cycle |
| alloc_grant | output | 1 | A tag is granted this cycle |
| alloc_tag | output | PTR_W | Granted tag, or all ones when nothing is granted |
| rel_req | input | 1 | Return a tag this cycle |
| rel_tag | input | PTR_W | Tag being returned |
| rel_err | output | 1 | The release this cycle was rejected |
| empty | output | 1 | No tag is free |
| free_cnt | output | PTR_W | Number of free tags |

## Verification
The bench drains the pool to empty and then asks again. A design that handled the sentinel wrongly would grant tag 31, or would wrap back to tag 0. Releases in a known order must come back reversed, which catches an allocator that behaves as a FIFO or simply picks the lowest free tag. A same-cycle release and allocate on an empty pool must return the released tag. A design that applied the allocation first would refuse the grant, or would leave the count off by one. Double releases and out-of-range tags must be rejected with the list intact, including when an allocation lands in the same cycle. A design that did not check in-use bits would corrupt the list, and the stale tag would later be handed out twice.

// File: rtl/tagpool_pkg.sv
package tagpool_pkg;

  // Operation applied to the free list in one cycle
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,  // no change to the list
    OP_POP  = 2'd1,  // head tag handed out
    OP_PUSH = 2'd2,  // released tag becomes head
    OP_SWAP = 2'd3   // released tag handed straight back out
  } pool_op_e;

endpackage

// File: rtl/tagpool_link_store.sv
module tagpool_link_store #(
  parameter int NUM_TAGS = 16,
  parameter int PTR_W    = $clog2(NUM_TAGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [PTR_W-1:0] wr_val,
  input  logic [PTR_W-1:0] rd_idx,
  output logic [PTR_W-1:0] rd_val
);

  localparam logic [PTR_W-1:0] NULL_PTR = '1;

  logic [PTR_W-1:0] link_q [NUM_TAGS];

  for (genvar i = 0; i < NUM_TAGS; i++) begin : g_link
    logic             hit;
    logic [PTR_W-1:0] init_val;

    assign hit      = wr_en && (wr_idx == PTR_W'(i));
    assign init_val = (i == NUM_TAGS - 1) ? NULL_PTR : PTR_W'(i + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        link_q[i] <= init_val;
      end else if (hit) begin
        link_q[i] <= wr_val;
      end
    end
  end

  // Read port; an out-of-range index (the sentinel) reads back null
  always_comb begin
    rd_val = NULL_PTR;
    for (int k = 0; k < NUM_TAGS; k++) begin
      if (rd_idx == PTR_W'(k)) rd_val = link_q[k];
    end
  end

endmodule

// File: rtl/tagpool_busy_bits.sv
module tagpool_busy_bits #(
  parameter int NUM_TAGS = 16,
  parameter int PTR_W    = $clog2(NUM_TAGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [PTR_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [PTR_W-1:0] clr_idx,
  input  logic [PTR_W-1:0] chk_idx,
  output logic             chk_busy
);

  logic [NUM_TAGS-1:0] busy_q;
  logic [NUM_TAGS-1:0] busy_d;

  always_comb begin
    busy_d = busy_q;
    for (int k = 0; k < NUM_TAGS; k++) begin
      if (set_en && set_idx == PTR_W'(k)) busy_d[k] = 1'b1;
      if (clr_en && clr_idx == PTR_W'(k)) busy_d[k] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else if (set_en || clr_en) begin
      busy_q <= busy_d;
    end
  end

  // Out-of-range indices are never busy
  always_comb begin
    chk_busy = 1'b0;
    for (int k = 0; k < NUM_TAGS; k++) begin
      if (chk_idx == PTR_W'(k)) chk_busy = busy_q[k];
    end
  end

endmodule

// File: rtl/tagpool_decide.sv
module tagpool_decide
  import tagpool_pkg::*;
#(
  parameter int NUM_TAGS = 16,
  parameter int PTR_W    = $clog2(NUM_TAGS + 1)
) (
  input  logic             alloc_req,
  input  logic             rel_req,
  input  logic [PTR_W-1:0] rel_tag,
  input  logic             rel_busy,
  input  logic [PTR_W-1:0] head_q,
  input  logic [PTR_W-1:0] head_link,
  output pool_op_e         op,
  output logic             grant,
  output logic [PTR_W-1:0] grant_tag,
  output logic             err,
  output logic [PTR_W-1:0] head_d,
  output logic             link_wr_en,
  output logic [PTR_W-1:0] link_wr_idx,
  output logic [PTR_W-1:0] link_wr_val
);

  localparam logic [PTR_W-1:0] NULL_PTR = '1;
  localparam logic [PTR_W-1:0] LAST_TAG = PTR_W'(NUM_TAGS - 1);

  logic rel_ok;
  logic have_free;

  assign rel_ok    = rel_req && (rel_tag <= LAST_TAG) && rel_busy;
  assign have_free = (head_q != NULL_PTR);

  always_comb begin
    op = OP_HOLD;
    if (rel_ok && alloc_req)        op = OP_SWAP;
    else if (rel_ok)                op = OP_PUSH;
    else if (alloc_req && have_free) op = OP_POP;
  end

  always_comb begin
    grant       = 1'b0;
    grant_tag   = NULL_PTR;
    head_d      = head_q;
    link_wr_en  = 1'b0;
    link_wr_idx = head_q;
    link_wr_val = NULL_PTR;
    unique case (op)
      OP_SWAP: begin
        grant     = 1'b1;
        grant_tag = rel_tag;
      end
      OP_PUSH: begin
        head_d      = rel_tag;
        link_wr_en  = 1'b1;
        link_wr_idx = rel_tag;
        link_wr_val = head_q;
      end
      OP_POP: begin
        grant       = 1'b1;
        grant_tag   = head_q;
        head_d      = head_link;
        link_wr_en  = 1'b1;
        link_wr_idx = head_q;
        link_wr_val = NULL_PTR;
      end
      default: ;
    endcase
  end

  assign err = rel_req && !rel_ok;

endmodule

// File: rtl/tagpool_count.sv
module tagpool_count #(
  parameter int NUM_TAGS = 16,
  parameter int CNT_W    = $clog2(NUM_TAGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = inc ^ dec;

  always_comb begin
    cnt_d = cnt_q;
    if (inc)      cnt_d = cnt_q + CNT_W'(1);
    else if (dec) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_W'(NUM_TAGS);
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/tagpool_top.sv
module tagpool_top
  import tagpool_pkg::*;
#(
  parameter int NUM_TAGS = 16,
  parameter int PTR_W    = $clog2(NUM_TAGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_req,
  output logic             alloc_grant,
  output logic [PTR_W-1:0] alloc_tag,
  input  logic             rel_req,
  input  logic [PTR_W-1:0] rel_tag,
  output logic             rel_err,
  output logic             empty,
  output logic [PTR_W-1:0] free_cnt
);

  localparam logic [PTR_W-1:0] NULL_PTR = '1;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  logic [PTR_W-1:0] head_q;
  logic [PTR_W-1:0] head_d;
  logic [PTR_W-1:0] head_link;
  logic             rel_busy;
  pool_op_e         op;
  logic             link_wr_en;
  logic [PTR_W-1:0] link_wr_idx;
  logic [PTR_W-1:0] link_wr_val;
  logic             head_en;

  tagpool_link_store #(.NUM_TAGS(NUM_TAGS), .PTR_W(PTR_W)) u_links (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (link_wr_en),
    .wr_idx (link_wr_idx),
    .wr_val (link_wr_val),
    .rd_idx (head_q),
    .rd_val (head_link)
  );

  tagpool_busy_bits #(.NUM_TAGS(NUM_TAGS), .PTR_W(PTR_W)) u_busy (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_en   (op == OP_POP),
    .set_idx  (head_q),
    .clr_en   (op == OP_PUSH),
    .clr_idx  (rel_tag),
    .chk_idx  (rel_tag),
    .chk_busy (rel_busy)
  );

  tagpool_decide #(.NUM_TAGS(NUM_TAGS), .PTR_W(PTR_W)) u_decide (
    .alloc_req   (alloc_req),
    .rel_req     (rel_req),
    .rel_tag     (rel_tag),
    .rel_busy    (rel_busy),
    .head_q      (head_q),
    .head_link   (head_link),
    .op          (op),
    .grant       (alloc_grant),
    .grant_tag   (alloc_tag),
    .err         (rel_err),
    .head_d      (head_d),
    .link_wr_en  (link_wr_en),
    .link_wr_idx (link_wr_idx),
    .link_wr_val (link_wr_val)
  );

  tagpool_count #(.NUM_TAGS(NUM_TAGS), .CNT_W(PTR_W)) u_count (
    .clk   (clk),
    .rst_n (rst_int_n),
    .inc   (op == OP_PUSH),
    .dec   (op == OP_POP),
    .cnt   (free_cnt)
  );

  assign head_en = (op == OP_PUSH) || (op == OP_POP);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      head_q <= '0;
    end else if (head_en) begin
      head_q <= head_d;
    end
  end

  assign empty = (head_q == NULL_PTR);

endmodule

// File: rtl/tagpool_checker.sv
module tagpool_checker #(
  parameter int NUM_TAGS = 16,
  parameter int PTR_W    = $clog2(NUM_TAGS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_req,
  input logic             alloc_grant,
  input logic [PTR_W-1:0] alloc_tag,
  input logic             rel_req,
  input logic [PTR_W-1:0] rel_tag,
  input logic             rel_err,
  input logic             empty,
  input logic [PTR_W-1:0] free_cnt,
  input logic [PTR_W-1:0] head_q
);

  localparam logic [PTR_W-1:0] NULL_PTR = '1;
  localparam logic [PTR_W-1:0] LAST_TAG = PTR_W'(NUM_TAGS - 1);

  // R7: the head pointer and the counter agree on emptiness
  a_r7_empty_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
    empty == (free_cnt == '0));

  // R7: the count never exceeds the pool size
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= PTR_W'(NUM_TAGS));

  // R2: a granted tag is always a real tag
  a_r2_grant_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_grant |-> alloc_tag <= LAST_TAG);

  // R2: a plain allocation removes one tag
  a_r2_pop_counts: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_grant && !rel_req) |=> free_cnt == $past(free_cnt) - PTR_W'(1));

  // R3: nothing is granted from an empty pool without a release
  a_r3_no_grant_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !rel_req) |-> (!alloc_grant && alloc_tag == NULL_PTR));

  // R4: an accepted lone release becomes the new head
  a_r4_push_to_head: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && !rel_err && !alloc_req) |=> head_q == $past(rel_tag));

  // R5: same-cycle release and allocate hand back the released tag
  a_r5_swap_returns_released: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && !rel_err && alloc_req) |-> (alloc_grant && alloc_tag == rel_tag));

  // R5: the swap leaves the count alone
  a_r5_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && !rel_err && alloc_req) |=> $stable(free_cnt));

  // R6: a rejected release alone changes nothing
  a_r6_reject_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_err && !alloc_req) |=> ($stable(free_cnt) && $stable(head_q)));

  // R6: an out-of-range tag is always rejected
  a_r6_range_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && rel_tag > LAST_TAG) |-> rel_err);

endmodule

bind tagpool_top tagpool_checker #(.NUM_TAGS(NUM_TAGS), .PTR_W(PTR_W)) u_checker (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .alloc_req   (alloc_req),
  .alloc_grant (alloc_grant),
  .alloc_tag   (alloc_tag),
  .rel_req     (rel_req),
  .rel_tag     (rel_tag),
  .rel_err     (rel_err),
  .empty       (empty),
  .free_cnt    (free_cnt),
  .head_q      (head_q)
);

// File: tb/tagpool_top_test.sv
`timescale 1ns/1ps
module tagpool_top_test;

  localparam int NUM_TAGS = 16;
  localparam int PTR_W    = 5;

  logic             clk;
  logic             rst_n;
  logic             alloc_req;
  logic             alloc_grant;
  logic [PTR_W-1:0] alloc_tag;
  logic             rel_req;
  logic [PTR_W-1:0] rel_tag;
  logic             rel_err;
  logic             empty;
  logic [PTR_W-1:0] free_cnt;

  int n_tests;
  int n_fail;

  tagpool_top #(.NUM_TAGS(NUM_TAGS), .PTR_W(PTR_W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_req   (alloc_req),
    .alloc_grant (alloc_grant),
    .alloc_tag   (alloc_tag),
    .rel_req     (rel_req),
    .rel_tag     (rel_tag),
    .rel_err     (rel_err),
    .empty       (empty),
    .free_cnt    (free_cnt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle of requests after a negedge, sample the same-cycle
  // outputs, then move to the next negedge with the requests removed.
  task automatic step(input logic a, input logic r, input logic [PTR_W-1:0] t,
                      output logic g, output logic [PTR_W-1:0] tg, output logic e);
    alloc_req = a;
    rel_req   = r;
    rel_tag   = t;
    #1;
    g  = alloc_grant;
    tg = alloc_tag;
    e  = rel_err;
    @(negedge clk);
    alloc_req = 1'b0;
    rel_req   = 1'b0;
    rel_tag   = '0;
  endtask

  task automatic t_reset;
    check("R1 reset free_cnt", int'(free_cnt), NUM_TAGS);
    check("R7 reset empty", int'(empty), 0);
  endtask

  task automatic t_drain;
    logic g, e;
    logic [PTR_W-1:0] tg;
    for (int i = 0; i < NUM_TAGS; i++) begin
      step(1'b1, 1'b0, '0, g, tg, e);
      check("R2 grant during drain", int'(g), 1);
      check("R1 ascending tag order", int'(tg), i);
    end
    check("R7 count after drain", int'(free_cnt), 0);
    check("R7 empty after drain", int'(empty), 1);
    step(1'b1, 1'b0, '0, g, tg, e);
    check("R3 no grant when empty", int'(g), 0);
    check("R3 null tag when empty", int'(tg), 31);
    check("R3 count stays zero", int'(free_cnt), 0);
  endtask

  task automatic t_lifo;
    logic g, e;
    logic [PTR_W-1:0] tg;
    step(1'b0, 1'b1, 5'd3, g, tg, e);
    check("R4 release 3 accepted", int'(e), 0);
    step(1'b0, 1'b1, 5'd7, g, tg, e);
    step(1'b0, 1'b1, 5'd5, g, tg, e);
    check("R7 count after three releases", int'(free_cnt), 3);
    check("R7 not empty", int'(empty), 0);
    step(1'b1, 1'b0, '0, g, tg, e);
    check("R4 first reuse is last released", int'(tg), 5);
    step(1'b1, 1'b0, '0, g, tg, e);
    check("R4 second reuse", int'(tg), 7);
    step(1'b1, 1'b0, '0, g, tg, e);
    check("R4 third reuse", int'(tg), 3);
    check("R7 count back to zero", int'(free_cnt), 0);
  endtask

  task automatic t_swap;
    logic g, e;
    logic [PTR_W-1:0] tg;
    step(1'b1, 1'b1, 5'd9, g, tg, e);
    check("R5 swap grant on empty pool", int'(g), 1);
    check("R5 swap returns released tag", int'(tg), 9);
    check("R5 swap no error", int'(e), 0);
    check("R5 swap keeps count", int'(free_cnt), 0);
    step(1'b0, 1'b1, 5'd2, g, tg, e);
    step(1'b0, 1'b1, 5'd4, g, tg, e);
    step(1'b1, 1'b1, 5'd11, g, tg, e);
    check("R5 swap with free tags returns released", int'(tg), 11);
    check("R5 count unchanged by swap", int'(free_cnt), 2);
    step(1'b1, 1'b0, '0, g, tg, e);
    check("R5 list intact after swap", int'(tg), 4);
    check("R7 count after pop", int'(free_cnt), 1);
  endtask

  task automatic t_bad_release;
    logic g, e;
    logic [PTR_W-1:0] tg;
    // tag 2 is free at this point
    step(1'b0, 1'b1, 5'd2, g, tg, e);
    check("R8 second release rejected", int'(e), 1);
    check("R6 count unchanged on reject", int'(free_cnt), 1);
    step(1'b0, 1'b1, 5'd20, g, tg, e);
    check("R6 out-of-range rejected", int'(e), 1);
    step(1'b0, 1'b1, 5'd31, g, tg, e);
    check("R6 null tag rejected", int'(e), 1);
    check("R6 count still unchanged", int'(free_cnt), 1);
    step(1'b1, 1'b0, '0, g, tg, e);
    check("R6 list intact after rejects", int'(tg), 2);
    step(1'b0, 1'b1, 5'd6, g, tg, e);
    check("R8 release of busy tag accepted", int'(e), 0);
    step(1'b1, 1'b1, 5'd6, g, tg, e);
    check("R6 reject with same-cycle alloc", int'(e), 1);
    check("R6 alloc served from head", int'(tg), 6);
    check("R6 alloc granted", int'(g), 1);
    check("R7 count after", int'(free_cnt), 0);
  endtask

  task automatic t_refill;
    logic g, e;
    logic [PTR_W-1:0] tg;
    for (int i = 0; i < NUM_TAGS; i++) begin
      step(1'b0, 1'b1, PTR_W'(i), g, tg, e);
      check("R8 refill release accepted", int'(e), 0);
    end
    check("R7 full count", int'(free_cnt), NUM_TAGS);
    step(1'b1, 1'b0, '0, g, tg, e);
    check("R4 top of refilled stack", int'(tg), 15);
    check("R7 count after refill pop", int'(free_cnt), NUM_TAGS - 1);
  endtask

  initial begin
    n_tests   = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    alloc_req = 1'b0;
    rel_req   = 1'b0;
    rel_tag   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_drain();
    t_lifo();
    t_swap();
    t_bad_release();
    t_refill();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule